// File: doc/BRIEF.md
# Floating-Point Pipeline Issue Controller

This block decides when a three-stage floating-point pipeline may take a new operation and reports when each accepted operation leaves it. It carries no operands and does no arithmetic. An upstream queue offers one operation per cycle over a valid/ready handshake, with a 3-bit class code and a 5-bit destination tag. The controller accepts the operation when no hazard is pending. Later it raises a one-cycle completion pulse that carries the tag back.

Four rules hold `in_ready` low:
- A divide holds the whole pipeline for its full duration.
- A double-precision multiply spends two cycles in the execute stage, so the slot after it is closed.
- After three back-to-back single-cycle operations, one empty cycle is forced.
- An operation that would finish no later than an operation already in flight must wait, so completions always leave in acceptance order.

Timing is tracked in a completion line indexed by the number of cycles each entry has left. Reset is synchronous and active-low.

Top module: `fp_issue_ctrl`

## Requirements
- R1: In the first cycle after `rst_n` is released, `done_valid` is 0. With `in_class` = 0, `in_ready` is 1.
- R2: Class codes: 0 is simple, 1 is single-precision multiply-add, 2 is double-precision multiply, 3 is divide, and 4 to 7 are treated as simple. A simple operation accepted in cycle c gives `done_valid` = 1 with its tag on `done_tag` during cycle c+3 only. Consecutive simple operations may be accepted in consecutive cycles.
- R3: A single-precision multiply-add (class 1) accepted in cycle c completes in cycle c+4. Multiply-adds may be accepted in consecutive cycles.
- R4: A double-precision multiply (class 2) accepted in cycle c completes in cycle c+4. `in_ready` is 0 in cycle c+1.
- R5: A divide (class 3) accepted in cycle c completes in cycle c+32. `in_ready` is 0 in cycles c+1 through c+31.
- R6: After single-cycle operations (classes 0, 1, 4 to 7) have been accepted in three consecutive cycles, `in_ready` is 0 in the next cycle. Any cycle without such an acceptance restarts this count.
- R7: `in_ready` is 0 whenever the offered operation would complete in the same cycle as, or before, an operation already in flight. For example, a simple operation is held in the cycle right after a multiply-add is accepted. `done_tag` values appear in acceptance order.
- R8: When `in_valid` is 0, no completion is scheduled and no state changes, except that the run count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The offered operation is accepted this cycle if `in_valid` is 1 |
| in_class | input | 3 | Operation class code |
| in_tag | input | 5 | Destination tag of the offered operation |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | 5 | Tag of the completing operation |

## Verification
The assertions assume that an offered operation follows valid/ready rules. They also assume that `in_valid` carries no meaning while `rst_n` is low, since every acceptance term they use is gated by reset.

The stimulus holds each offered operation, class and tag unchanged, until the cycle in which the reference model predicts acceptance, and only then moves to the next operation. Class codes 4 to 7 are sent as well, so the rule that treats them as simple is exercised. Tags advance by one per accepted operation, so any reordering or loss of a completion shows up as a tag mismatch.

// File: rtl/fpic_pkg.sv
// Package: class codes and the coarse operation kind shared by the
// decoder, the hazard gate and the top level.
// Assumes: class field is three bits wide; codes above 3 act as simple.
package fpic_pkg;

    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] CLS_SIMPLE = 3'd0;
    localparam logic [CLS_W-1:0] CLS_SPFMA  = 3'd1;
    localparam logic [CLS_W-1:0] CLS_DPMUL  = 3'd2;
    localparam logic [CLS_W-1:0] CLS_DIV    = 3'd3;

    // Hazard-relevant grouping of classes.
    typedef enum logic [1:0] {
        KIND_SINGLE = 2'd0,
        KIND_DPMUL  = 2'd1,
        KIND_DIV    = 2'd2
    } op_kind_t;

endpackage

// File: rtl/fpic_class_decode.sv
// Class decoder: maps the class code onto a hazard kind and a total
// latency, counted in cycles from acceptance to the completion pulse.
// Assumes: every latency is at least 1 and fits in IDX_W bits.
module fpic_class_decode
    import fpic_pkg::*;
#(
    parameter int LAT_SINGLE = 3,
    parameter int LAT_SPFMA  = 4,
    parameter int LAT_DPMUL  = 4,
    parameter int LAT_DIV    = 32,
    parameter int IDX_W      = 6
) (
    input  logic [CLS_W-1:0] cls,
    output op_kind_t         kind,
    output logic [IDX_W-1:0] lat
);

    // Look up the kind and the latency of the offered class.
    always_comb begin
        kind = KIND_SINGLE;
        lat  = IDX_W'(LAT_SINGLE);
        unique case (cls)
            CLS_SPFMA: begin
                kind = KIND_SINGLE;
                lat  = IDX_W'(LAT_SPFMA);
            end
            CLS_DPMUL: begin
                kind = KIND_DPMUL;
                lat  = IDX_W'(LAT_DPMUL);
            end
            CLS_DIV: begin
                kind = KIND_DIV;
                lat  = IDX_W'(LAT_DIV);
            end
            default: begin
                kind = KIND_SINGLE;
                lat  = IDX_W'(LAT_SINGLE);
            end
        endcase
    end

endmodule

// File: rtl/fpic_slot_line.sv
// Completion line: slot i holds the operation that completes i cycles
// after the current one. Every cycle the line shifts down by one. A new
// entry with latency L is written into slot L-1. Slot 0 drives the
// completion outputs.
// Assumes: the issuer never writes an entry while slot L is occupied.
// The hazard gate guarantees this through the occupancy vector.
module fpic_slot_line #(
    parameter int DEPTH = 32,
    parameter int TAG_W = 5,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins,
    input  logic [IDX_W-1:0] ins_lat,
    input  logic [TAG_W-1:0] ins_tag,
    output logic [DEPTH-1:0] occ,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag
);

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [DEPTH-1:0] vld_up;
    logic [TAG_W-1:0] tag_up [DEPTH];
    logic             clash;

    // The next-higher neighbour of each slot; the top slot takes an empty entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_up
        if (g == DEPTH - 1) begin : g_top
            assign vld_up[g] = 1'b0;
            assign tag_up[g] = '0;
        end else begin : g_mid
            assign vld_up[g] = vld_q[g+1];
            assign tag_up[g] = tag_q[g+1];
        end
    end

    // Shift the line by one and write the accepted entry into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ins && ins_lat == IDX_W'(i + 1)) begin
                    vld_q[i] <= 1'b1;
                    tag_q[i] <= ins_tag;
                end else begin
                    vld_q[i] <= vld_up[i];
                    tag_q[i] <= tag_up[i];
                end
            end
        end
    end

    // Flag a write that would replace an entry shifting into the same slot.
    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (ins && ins_lat == IDX_W'(i + 1) && vld_q[i+1]) clash = 1'b1;
        end
    end

    assign occ        = vld_q;
    assign done_valid = vld_q[0];
    assign done_tag   = tag_q[0];

    // R7
    slot_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clash);

endmodule

// File: rtl/fpic_hazard_gate.sv
// Hazard gate: forms in_ready from four rules.
//   1. A divide holds the whole pipeline for its full duration.
//   2. A double-precision multiply closes the slot right after it.
//   3. A bubble is forced after RUN_MAX consecutive single-cycle acceptances.
//   4. An operation that would overtake one in flight is held.
// Assumes: occ[j] is set when an entry completes j cycles from now.
module fpic_hazard_gate
    import fpic_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int IDX_W   = 6,
    parameter int LAT_DIV = 32,
    parameter int RUN_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  op_kind_t         kind,
    input  logic [IDX_W-1:0] lat,
    input  logic [DEPTH-1:0] occ,
    output logic             in_ready
);

    localparam int CNT_W = $clog2(LAT_DIV);
    localparam int RUN_W = $clog2(RUN_MAX + 1);

    logic [CNT_W-1:0] div_cnt_q;
    logic             dp_hold_q;
    logic [RUN_W-1:0] run_cnt_q;
    logic             late;
    logic             acc;
    logic             acc_single;

    // Detect an in-flight entry that completes no earlier than the offered one.
    always_comb begin
        late = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (occ[j] && (IDX_W'(j) >= lat)) late = 1'b1;
        end
    end

    // Combine the four hold conditions into in_ready.
    always_comb begin
        in_ready = (div_cnt_q == '0) && !dp_hold_q &&
                   (run_cnt_q != RUN_W'(RUN_MAX)) && !late;
    end

    assign acc        = rst_n && in_valid && in_ready;
    assign acc_single = acc && (kind == KIND_SINGLE);

    // Count down the cycles for which an accepted divide owns the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n)                        div_cnt_q <= '0;
        else if (acc && kind == KIND_DIV)  div_cnt_q <= CNT_W'(LAT_DIV - 1);
        else if (div_cnt_q != '0)          div_cnt_q <= div_cnt_q - 1'b1;
    end

    // Close the slot that follows a double-precision multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) dp_hold_q <= 1'b0;
        else        dp_hold_q <= acc && (kind == KIND_DPMUL);
    end

    // Count consecutive single-cycle acceptances; any other cycle clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_cnt_q <= '0;
        else if (acc_single) run_cnt_q <= run_cnt_q + 1'b1;
        else                 run_cnt_q <= '0;
    end

    // R5
    div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == KIND_DIV) |=> !in_ready);

    // R4
    dp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == KIND_DPMUL) |=> !in_ready);

    // R6
    run_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_single && $past(acc_single, 1) && $past(acc_single, 2)) |=> !in_ready);

endmodule

// File: rtl/fp_issue_ctrl.sv
// Top level: issue and completion controller for a three-stage
// floating-point pipeline. It has no datapath: it accepts one tagged
// operation per cycle, applies the divide, double-multiply, forced-bubble
// and ordering holds, and pulses the tag back on completion.
// Assumes: LAT_DIV is the longest latency and sets the line depth.
module fp_issue_ctrl
    import fpic_pkg::*;
#(
    parameter int TAG_W      = 5,
    parameter int LAT_SINGLE = 3,
    parameter int LAT_SPFMA  = 4,
    parameter int LAT_DPMUL  = 4,
    parameter int LAT_DIV    = 32,
    parameter int RUN_MAX    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_class,
    input  logic [TAG_W-1:0] in_tag,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag
);

    localparam int DEPTH = LAT_DIV;
    localparam int IDX_W = $clog2(DEPTH + 1);

    op_kind_t         kind;
    logic [IDX_W-1:0] lat;
    logic [DEPTH-1:0] occ;
    logic             accept;

    fpic_class_decode #(
        .LAT_SINGLE (LAT_SINGLE),
        .LAT_SPFMA  (LAT_SPFMA),
        .LAT_DPMUL  (LAT_DPMUL),
        .LAT_DIV    (LAT_DIV),
        .IDX_W      (IDX_W)
    ) u_decode (
        .cls  (in_class),
        .kind (kind),
        .lat  (lat)
    );

    fpic_hazard_gate #(
        .DEPTH   (DEPTH),
        .IDX_W   (IDX_W),
        .LAT_DIV (LAT_DIV),
        .RUN_MAX (RUN_MAX)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .kind     (kind),
        .lat      (lat),
        .occ      (occ),
        .in_ready (in_ready)
    );

    assign accept = rst_n && in_valid && in_ready;

    fpic_slot_line #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins        (accept),
        .ins_lat    (lat),
        .ins_tag    (in_tag),
        .occ        (occ),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    if (LAT_SINGLE == 3) begin : g_lat_chk
        // R2
        simple_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && in_class == CLS_SIMPLE) |-> ##3
            (done_valid && done_tag == $past(in_tag, 3)));
    end

endmodule

// File: tb/fp_issue_ctrl_bench.sv
module fp_issue_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_class = 3'd0;
    logic [4:0] in_tag = 5'd0;
    logic       in_ready;
    logic       done_valid;
    logic [4:0] done_tag;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    // Reference model state
    int cyc = 0;
    int div_rem = 0;
    bit dp_hold = 1'b0;
    int run = 0;
    int q_tag [64];
    int q_due [64];
    int q_cls [64];
    int head = 0;
    int tail = 0;
    bit last_acc;
    int next_tag = 0;

    always #4 clk = ~clk;

    fp_issue_ctrl u_fp_issue_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_class   (in_class),
        .in_tag     (in_tag),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    function automatic int lat_of(input int c);
        if (c == 1) return 4;
        if (c == 2) return 4;
        if (c == 3) return 32;
        return 3;
    endfunction

    function automatic bit is_single(input int c);
        return (c != 2) && (c != 3);
    endfunction

    function automatic bit late_of(input int L);
        for (int k = head; k != tail; k = (k + 1) % 64) begin
            if (q_due[k] >= cyc + L) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic string req_of_cls(input int c);
        if (c == 1) return "R3";
        if (c == 2) return "R4";
        if (c == 3) return "R5";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic step(input bit v, input int c, input int tg);
        bit    er;
        bit    lt;
        bit    acc;
        string rq;
        @(negedge clk);
        in_valid = v;
        in_class = 3'(c);
        in_tag   = 5'(tg);
        #1;
        lt = late_of(lat_of(c));
        er = (div_rem == 0) && !dp_hold && (run < 3) && !lt;
        if (cyc == 0)         rq = "R1";
        else if (div_rem > 0) rq = "R5";
        else if (dp_hold)     rq = "R4";
        else if (run >= 3)    rq = "R6";
        else if (lt)          rq = "R7";
        else                  rq = "R2";
        chk(in_ready === er, rq, "in_ready", int'(in_ready), int'(er));
        if (head != tail && q_due[head] == cyc) begin
            chk(done_valid === 1'b1, req_of_cls(q_cls[head]), "done_valid",
                int'(done_valid), 1);
            chk(done_tag === 5'(q_tag[head]), "R7", "done_tag",
                int'(done_tag), q_tag[head]);
            head = (head + 1) % 64;
        end else begin
            chk(done_valid === 1'b0, (cyc == 0) ? "R1" : "R8", "done_valid",
                int'(done_valid), 0);
        end
        acc = v && er;
        last_acc = acc;
        if (acc) begin
            q_tag[tail] = tg;
            q_due[tail] = cyc + lat_of(c);
            q_cls[tail] = c;
            tail = (tail + 1) % 64;
        end
        if (acc && c == 3)    div_rem = 31;
        else if (div_rem > 0) div_rem--;
        dp_hold = acc && (c == 2);
        run = (acc && is_single(c)) ? run + 1 : 0;
        cyc++;
    endtask

    // Offer one operation and hold it until the model accepts it.
    task automatic push_op(input int c);
        last_acc = 1'b0;
        while (!last_acc) step(1'b1, c, next_tag);
        next_tag = (next_tag + 1) % 32;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    initial begin
        int r;
        int c;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        idle(1);
        // R2, R6: five simple back to back, a bubble after the third
        for (int i = 0; i < 5; i++) push_op(0);
        idle(4);
        // R6: an idle cycle restarts the run count
        push_op(0); push_op(0); idle(1);
        for (int i = 0; i < 3; i++) push_op(0);
        idle(4);
        // R3, R7: multiply-add then simple, then a multiply-add stream
        push_op(1); push_op(0);
        for (int i = 0; i < 4; i++) push_op(1);
        idle(5);
        // R4: two double multiplies then a simple
        push_op(2); push_op(2); push_op(0);
        idle(5);
        // R2: codes above 3 act as simple
        push_op(6); push_op(4); push_op(7);
        idle(5);
        // R5: divide, then a simple waiting the whole divide
        push_op(0); push_op(3); push_op(0); push_op(1);
        idle(40);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            r = int'($urandom % 100);
            if (r < 25) begin
                idle(1);
            end else begin
                r = int'($urandom % 100);
                if (r < 4)       c = 3;
                else if (r < 20) c = 2;
                else if (r < 40) c = 1;
                else if (r < 48) c = 4 + int'($urandom % 4);
                else             c = 0;
                push_op(c);
            end
        end
        idle(40);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 150000, 0);
        summary();
    end

endmodule